// File: doc/BRIEF.md
# First-Fault Bus Address Capture

This block watches the bus-fault indications of three bus masters: a CPU, a DMA engine and an Ethernet MAC. When a master reports a fault, the block sets a sticky flag for that master and stores the address of the faulting access. Only the first fault after a clear is recorded. Further faults from the same master leave the stored address unchanged until software clears that master's flag. The clear re-arms capture for that master.

Software reaches the block through a simple 32-bit register port with write strobe, offset, write data and combinational read data. There are five registers:

- A flag register.
- A clear register that only acts when its write carries a 16-bit key.
- One address register per master.

No register lets software set a flag.

Top module: `bus_fault_capture`

## Requirements
- R1: After reset, every flag is 0 and every captured address reads 0. Reads return 0 at offsets 0x50, 0x54, 0x58, 0x5C and 0x60.
- R2: A fault pulse from a master sets its flag bit in the flag register at offset 0x50. Bit 0 is the CPU, bit 1 the DMA engine and bit 2 the MAC. Bits 31:3 read as 0. The flag is visible from the clock edge that samples the fault.
- R3: On a fault while its flag is clear, a master's address is stored. The stored address is readable at 0x58 for the CPU, 0x5C for DMA and 0x60 for the MAC.
- R4: While a master's flag is set, later faults from that master do not change its stored address.
- R5: A write to offset 0x54 whose bits 31:16 equal 0xA5A5 clears each flag whose bit (0 CPU, 1 DMA, 2 MAC) is written 1. Flags written 0 are unchanged.
- R6: A write to 0x54 whose bits 31:16 differ from 0xA5A5 changes no flag.
- R7: After a master's flag has been cleared, its next fault stores the new address.
- R8: A fault that coincides with a valid clear of the same master leaves the flag set and stores the new address.
- R9: Only faults set flags, and only the keyed clear removes them. Writes to 0x50 or to an address register change nothing. Reads of 0x54 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_valid | input | 3 | One-cycle fault pulse per master: bit 0 CPU, bit 1 DMA, bit 2 MAC |
| fault_addr | input | 96 | Faulting address per master, CPU in bits 31:0, DMA in 63:32, MAC in 95:64 |
| reg_wr | input | 1 | Register write strobe |
| reg_offset | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_offset, combinational |

## Verification
The assertions assume that `fault_addr` is meaningful only in a cycle where the matching `fault_valid` bit is high. They also assume that register writes and faults are sampled at the same edge, with no ordering between them except the same-cycle rule of R8. The stimulus drives faults and writes on the falling edge and holds each for exactly one cycle. It keeps `fault_valid` low whenever it reads, so each read sees a settled register state. It includes one cycle where a fault and a keyed clear of the same master coincide.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int DATA_W   = 32;
  localparam int OFF_W    = 8;
  localparam logic [15:0] CLR_KEY = 16'hA5A5;
  localparam logic [OFF_W-1:0] OFF_FLAGS = 8'h50;
  localparam logic [OFF_W-1:0] OFF_CLEAR = 8'h54;
  localparam logic [OFF_W-1:0] OFF_ADDR0 = 8'h58;

  function automatic logic [OFF_W-1:0] slot_offset(input int idx);
    return OFF_ADDR0 + OFF_W'(4 * idx);
  endfunction

  function automatic logic key_match(input logic [DATA_W-1:0] wdata);
    return wdata[31:16] == CLR_KEY;
  endfunction
endpackage

// File: rtl/bfc_wr_decode.sv
module bfc_wr_decode
  import bfc_pkg::*;
#(
  parameter int NUM_MASTERS = 3
) (
  input  logic                    reg_wr,
  input  logic [OFF_W-1:0]        reg_offset,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [NUM_MASTERS-1:0]  clr_mask
);
  logic clr_hit;
  logic key_ok;

  assign clr_hit  = reg_wr && (reg_offset == OFF_CLEAR);
  assign key_ok   = key_match(reg_wdata);
  assign clr_mask = (clr_hit && key_ok) ? reg_wdata[NUM_MASTERS-1:0] : '0;
endmodule

// File: rtl/bfc_slot.sv
module bfc_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic              clr,
  output logic              flag_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic armed;
  logic capture;

  assign armed   = !flag_q || clr;
  assign capture = fault && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
    end else begin
      flag_q <= fault || (flag_q && !clr);
      if (capture) addr_q <= fault_addr;
    end
  end

  a_r2_fault_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> flag_q);
  a_r4_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> $stable(addr_q));
  a_r5_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fault) |=> !flag_q);
  a_r7_rearmed_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && (!flag_q || clr)) |=> (addr_q == $past(fault_addr)));
endmodule

// File: rtl/bfc_rd_mux.sv
module bfc_rd_mux
  import bfc_pkg::*;
#(
  parameter int NUM_MASTERS = 3,
  parameter int ADDR_W      = 32
) (
  input  logic [OFF_W-1:0]              reg_offset,
  input  logic [NUM_MASTERS-1:0]        flags,
  input  logic [NUM_MASTERS*ADDR_W-1:0] addrs,
  output logic [DATA_W-1:0]             reg_rdata
);
  always_comb begin
    reg_rdata = '0;
    if (reg_offset == OFF_FLAGS) reg_rdata = DATA_W'(flags);
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (reg_offset == slot_offset(i))
        reg_rdata = DATA_W'(addrs[i*ADDR_W +: ADDR_W]);
    end
  end
endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
  import bfc_pkg::*;
#(
  parameter int NUM_MASTERS = 3,
  parameter int ADDR_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_MASTERS-1:0]        fault_valid,
  input  logic [NUM_MASTERS*ADDR_W-1:0] fault_addr,
  input  logic                          reg_wr,
  input  logic [OFF_W-1:0]              reg_offset,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata
);
  logic [NUM_MASTERS-1:0]        clr_mask;
  logic [NUM_MASTERS-1:0]        flags;
  logic [NUM_MASTERS*ADDR_W-1:0] addrs;
  logic                          bad_key_clear;

  bfc_wr_decode #(.NUM_MASTERS(NUM_MASTERS)) u_dec (
    .reg_wr(reg_wr), .reg_offset(reg_offset), .reg_wdata(reg_wdata),
    .clr_mask(clr_mask)
  );

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_slot
    bfc_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .fault(fault_valid[g]),
      .fault_addr(fault_addr[g*ADDR_W +: ADDR_W]),
      .clr(clr_mask[g]),
      .flag_q(flags[g]),
      .addr_q(addrs[g*ADDR_W +: ADDR_W])
    );
  end

  bfc_rd_mux #(.NUM_MASTERS(NUM_MASTERS), .ADDR_W(ADDR_W)) u_rd (
    .reg_offset(reg_offset), .flags(flags), .addrs(addrs),
    .reg_rdata(reg_rdata)
  );

  assign bad_key_clear = reg_wr && (reg_offset == OFF_CLEAR) &&
                         (reg_wdata[31:16] != CLR_KEY);

  a_r6_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_key_clear && fault_valid == '0) |=> $stable(flags));
  a_r9_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid == '0) |=> ((flags & ~$past(flags)) == '0));
endmodule

// File: tb/bus_fault_capture_bench.sv
module bus_fault_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fault_valid = '0;
  logic [95:0] fault_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_offset = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  logic        m_flag [3];
  logic [31:0] m_addr [3];

  bus_fault_capture u_bus_fault_capture (
    .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_addr(fault_addr),
    .reg_wr(reg_wr), .reg_offset(reg_offset), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  always #2 clk = ~clk;

  // monitor: compares one queued expectation per cycle, 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        checks++;
        if (reg_rdata !== it.exp) begin
          failures++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  // one cycle of faults and/or a register write; the model follows the requirements
  task automatic step(input logic [2:0] fmask, input logic [31:0] a0,
                      input logic [31:0] a1, input logic [31:0] a2,
                      input logic wr, input logic [7:0] off, input logic [31:0] wd);
    logic [31:0] av [3];
    logic [2:0]  clr;
    av[0] = a0; av[1] = a1; av[2] = a2;
    clr = (wr && off == 8'h54 && wd[31:16] == 16'hA5A5) ? wd[2:0] : 3'b000;
    for (int i = 0; i < 3; i++) begin
      if (fmask[i]) begin
        if (!m_flag[i] || clr[i]) m_addr[i] = av[i];
        m_flag[i] = 1'b1;
      end else if (clr[i]) begin
        m_flag[i] = 1'b0;
      end
    end
    @(negedge clk);
    fault_valid = fmask;
    fault_addr  = {a2, a1, a0};
    reg_wr = wr; reg_offset = off; reg_wdata = wd;
    @(negedge clk);
    fault_valid = '0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, input logic [31:0] exp, input string tag);
    exp_t it;
    @(negedge clk);
    reg_offset = off;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #2;
  endtask

  task automatic rd_all(input string tag);
    rd(8'h50, {29'd0, m_flag[2], m_flag[1], m_flag[0]}, tag);
    rd(8'h58, m_addr[0], tag);
    rd(8'h5C, m_addr[1], tag);
    rd(8'h60, m_addr[2], tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin m_flag[i] = 1'b0; m_addr[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd_all("R1 reset");
    rd(8'h54, 32'h0, "R1 clear reg");
    // R2 R3 first CPU fault
    step(3'b001, 32'h1000_0040, 0, 0, 0, 0, 0);
    rd_all("R2 R3 cpu first fault");
    // R4 CPU fault again, R3 DMA first fault
    step(3'b011, 32'h2222_0000, 32'h3000_0008, 0, 0, 0, 0);
    rd_all("R4 held cpu addr, R3 dma");
    // R6 wrong key
    step(3'b000, 0, 0, 0, 1'b1, 8'h54, 32'h5A5A_0007);
    rd_all("R6 wrong key");
    // R5 keyed clear of DMA only
    step(3'b000, 0, 0, 0, 1'b1, 8'h54, 32'hA5A5_0002);
    rd_all("R5 clear dma only");
    // R7 re-armed DMA capture
    step(3'b010, 0, 32'h3000_00F0, 0, 0, 0, 0);
    rd_all("R7 dma rearmed");
    // R2 R3 MAC
    step(3'b100, 0, 0, 32'hDEAD_BEE0, 0, 0, 0);
    rd_all("R2 R3 mac");
    // R9 writes to non-clear registers
    step(3'b000, 0, 0, 0, 1'b1, 8'h50, 32'hFFFF_FFFF);
    step(3'b000, 0, 0, 0, 1'b1, 8'h58, 32'h1234_5678);
    rd_all("R9 no soft write");
    rd(8'h54, 32'h0, "R9 clear reads zero");
    rd(8'h44, 32'h0, "R9 unmapped");
    rd(8'h64, 32'h0, "R9 unmapped");
    // R8 fault coinciding with keyed clear
    step(3'b001, 32'h4444_0000, 0, 0, 1'b1, 8'h54, 32'hA5A5_0001);
    rd_all("R8 same-cycle fault and clear");
    // R5 clear everything
    step(3'b000, 0, 0, 0, 1'b1, 8'h54, 32'hA5A5_0007);
    rd(8'h50, 32'h0, "R5 clear all");
    // R7 after full clear, the MAC captures again
    step(3'b100, 0, 0, 32'h0BAD_0004, 0, 0, 0);
    rd_all("R7 mac rearmed");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule